// File: doc/BRIEF.md
# E1 Frame and Multiframe Aligner

This block sits on the receive side of a 2.048 Mbit/s E1 port and locates frame boundaries in an unframed serial bit stream. Each frame is 256 bits long and holds 32 eight-bit time slots. Bits arrive one at a time on `rx_bit`. A bit counts only in a cycle where `bit_en` is high. Within a time slot the first bit received is bit 1 and the last is bit 8.

The aligner hunts for the alignment word in time slot 0 and confirms it through an alternate-frame check. Once the frame is locked, it can search for the CRC-4 multiframe, which is carried in bit 1 of the non-alignment frames. A search window bounds that hunt, and a retry counter records how many windows expired. The aligner also finds the signalling multiframe in time slot 16. Position strobes, search flags and loss/timeout pulses go to the downstream framer logic.

Top module: `e1_frame_sync`

## Requirements
- R1: After reset, `fas_search` is 1, `crc_search` and `cas_search` are 0, `crc_retry` is 0, and every strobe and pulse output is 0.
- R2: A cycle with `bit_en` low leaves the alignment state unchanged, whatever value `rx_bit` has in that cycle.
- R3: Frame lock requires three frames in a row, N, N+1 and N+2:
  - frame N has 0011011 in bits 2..8 of time slot 0;
  - frame N+1 has bit 2 of time slot 0 equal to 1;
  - frame N+2 again has 0011011 in bits 2..8.
  `fas_search` falls one clock after the cycle that carries bit 8 of time slot 0 in frame N+2.
- R4: If any step of R3 fails, the search returns to hunting bit by bit, and the frame does not lock.
- R5: While the frame is locked, `frame_stb` gives a one-clock pulse one clock after bit 8 of time slot 0 of each alignment frame, that is, once every second frame. It stays 0 after non-alignment frames.
- R6: While locked, three alignment words in a row received with errors make `fas_lost` pulse and `fas_search` rise, in the same clock. Two errored words followed by a correct one keep the lock.
- R7: With `crc4_en` high and the frame locked, `crc_search` stays 1 until it sees two multiframe words 16 frames apart. The multiframe word is 001011, read from bit 1 of time slot 0 of the non-alignment frames 1, 3, 5, 7, 9 and 11, with frame 1 first. With `crc4_en` low, `crc_search` stays 0 and no timeout occurs.
- R8: Once the CRC-4 multiframe is locked, `crc_mf_stb` pulses one clock after bit 8 of time slot 0 of multiframe frame 0, and at no other point.
- R9: If 64 frames pass in CRC-4 search without lock:
  - `crc_timeout` pulses;
  - `crc_retry` increases by one, saturating at 63;
  - `fas_search` returns to 1 and frame hunting restarts.
- R10: `crc_retry` clears to 0 when CRC-4 multiframe lock is reached.
- R11: While the frame is locked, signalling multiframe lock occurs when time slot 16 holds 0000 in bits 1..4 and the time slot 16 of the previous frame was not all zeros. Lock is then shown by `cas_search` falling one clock after bit 8 of that slot. If the previous slot was all zeros, no lock results.
- R12: After signalling multiframe lock, `cas_mf_stb` pulses one clock after bit 8 of time slot 16, every 16 frames. The first pulse comes 16 frames after the lock frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Received serial data bit |
| crc4_en | input | 1 | Enables the CRC-4 multiframe search |
| frame_stb | output | 1 | Alignment-frame position pulse |
| crc_mf_stb | output | 1 | CRC-4 multiframe start pulse |
| cas_mf_stb | output | 1 | Signalling multiframe start pulse |
| fas_search | output | 1 | Frame alignment search active |
| crc_search | output | 1 | CRC-4 multiframe search active |
| cas_search | output | 1 | Signalling multiframe search active |
| fas_lost | output | 1 | Pulse on loss of frame alignment |
| crc_timeout | output | 1 | Pulse on expiry of the CRC-4 window |
| crc_retry | output | 6 | Count of expired CRC-4 windows |

## Verification
Clean streams are sent with different numbers of leading filler bits, so frame lock is shown to depend only on the word pattern and not on where the stream starts. Three faulty streams each break one step of the three-frame check: a bad first word, a zero in the non-alignment bit, and a bad confirming word. Each must then prevent the lock at its own frame. A stream with idle cycles carrying inverted data tells real bits apart from unqualified ones. Stepwise error streams separate two errors from three. A stream without multiframe words tells timeout and retry apart from a stream that carries them, and a zero-filled signalling slot tells the previous-slot condition apart from a plain nibble match.

// File: rtl/e1_frame_sync.sv
module e1_frame_sync #(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter int CAS_SLOT   = 16,
  parameter int LOSS_ERRS  = 3,
  parameter int CRC_WIN    = 64,
  parameter int MF_FRAMES  = 16,
  parameter logic [6:0] FAS_WORD  = 7'b0011011,
  parameter logic [5:0] MFAS_WORD = 6'b001011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       crc4_en,
  output logic       frame_stb,
  output logic       crc_mf_stb,
  output logic       cas_mf_stb,
  output logic       fas_search,
  output logic       crc_search,
  output logic       cas_search,
  output logic       fas_lost,
  output logic       crc_timeout,
  output logic [5:0] crc_retry
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam int EW = $clog2(LOSS_ERRS + 1);
  localparam int WW = $clog2(CRC_WIN);
  localparam int MW = $clog2(MF_FRAMES);
  localparam int TS0_END  = SLOT_BITS - 1;
  localparam int TS16_END = CAS_SLOT * SLOT_BITS + SLOT_BITS - 1;
  localparam int MF_LAST  = 11;

  typedef enum logic [1:0] {HUNT, CHK_N, CHK_F, LOCK} st_t;

  st_t           st;
  logic [6:0]    sr;
  logic [PW-1:0] pos;
  logic          expect_fas;
  logic [EW-1:0] errs;
  logic [5:0]    crc_sr;
  logic          crc_have, crc_lock;
  logic [MW-1:0] mf_pos, cas_pos;
  logic [WW-1:0] win;
  logic          cas_lock, prev_nz;

  wire [7:0] octet   = {sr, rx_bit};
  wire       fas_ok  = octet[6:0] == FAS_WORD;
  wire       mf_hit  = {crc_sr[4:0], octet[7]} == MFAS_WORD;
  wire       in_lock = st == LOCK;
  wire       ts0_end  = bit_en && pos == PW'(TS0_END);
  wire       ts16_end = bit_en && pos == PW'(TS16_END);
  wire       crc_hunt = in_lock && crc4_en && !crc_lock;
  wire       chk_fas  = in_lock && ts0_end && expect_fas;
  wire       nfas_t   = in_lock && ts0_end && !expect_fas;
  wire       fas_drop = chk_fas && !fas_ok && errs == EW'(LOSS_ERRS - 1);
  wire       crc_now  = crc_hunt && nfas_t && mf_hit && crc_have && mf_pos == MW'(MF_LAST);
  wire       win_out  = crc_hunt && ts0_end && win == WW'(CRC_WIN - 1) && !crc_now;

  assign fas_search = !in_lock;
  assign crc_search = crc_hunt;
  assign cas_search = in_lock && !cas_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; sr <= '0; pos <= '0; expect_fas <= 1'b0; errs <= '0;
      crc_sr <= '0; crc_have <= 1'b0; crc_lock <= 1'b0; mf_pos <= '0; win <= '0;
      cas_lock <= 1'b0; prev_nz <= 1'b0; cas_pos <= '0; crc_retry <= '0;
      frame_stb <= 1'b0; crc_mf_stb <= 1'b0; cas_mf_stb <= 1'b0;
      fas_lost <= 1'b0; crc_timeout <= 1'b0;
    end else begin
      frame_stb   <= chk_fas;
      crc_mf_stb  <= in_lock && ts0_end && crc_lock && mf_pos == '0;
      cas_mf_stb  <= in_lock && ts16_end && cas_lock && cas_pos == '0;
      fas_lost    <= fas_drop;
      crc_timeout <= win_out;
      if (bit_en) begin
        sr  <= octet[6:0];
        pos <= (pos == PW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
      end
      case (st)
        HUNT: if (bit_en && fas_ok) begin
          st <= CHK_N; pos <= PW'(TS0_END + 1); expect_fas <= 1'b0;
        end
        CHK_N: if (ts0_end) begin
          st <= octet[6] ? CHK_F : HUNT; expect_fas <= 1'b1;
        end
        CHK_F: if (ts0_end) begin
          st <= fas_ok ? LOCK : HUNT; expect_fas <= 1'b0; mf_pos <= '0;
        end
        default: begin
          if (ts0_end) expect_fas <= !expect_fas;
          if (chk_fas) errs <= fas_ok ? '0 : errs + 1'b1;
        end
      endcase
      if (in_lock) begin
        if (nfas_t) crc_sr <= {crc_sr[4:0], octet[7]};
        if (ts0_end) mf_pos <= mf_pos + 1'b1;
        if (crc_hunt && nfas_t && mf_hit && !crc_now) begin
          crc_have <= 1'b1; mf_pos <= MW'(MF_LAST + 1);
        end
        if (crc_now) begin crc_lock <= 1'b1; crc_retry <= '0; end
        if (crc_hunt && ts0_end) win <= win + 1'b1;
        if (win_out && crc_retry != 6'd63) crc_retry <= crc_retry + 1'b1;
        if (ts16_end) begin
          prev_nz <= |octet;
          if (cas_lock) cas_pos <= cas_pos + 1'b1;
          else if (octet[7:4] == 4'b0000 && prev_nz) begin
            cas_lock <= 1'b1; cas_pos <= MW'(1);
          end
        end
      end else begin
        errs <= '0; crc_sr <= '0; crc_have <= 1'b0; crc_lock <= 1'b0; win <= '0;
        cas_lock <= 1'b0; prev_nz <= 1'b0;
      end
      if (fas_drop || win_out) st <= HUNT;
    end
  end

  // R6
  lost_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fas_lost |-> fas_search);
  // R9
  timeout_hunts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_timeout |-> fas_search);
  // R5
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);
  // R10
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(crc_search) && !fas_search && crc4_en) |-> crc_retry == 6'd0);
  // R8
  crc_stb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_mf_stb |-> !crc_search);
  // R12
  cas_stb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_mf_stb |-> !cas_search && !fas_search);
endmodule

// File: tb/sim_e1_frame_sync.sv
module sim_e1_frame_sync;
  localparam int CLK_T = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b0, crc4_en = 1'b0;
  logic frame_stb, crc_mf_stb, cas_mf_stb, fas_search, crc_search, cas_search;
  logic fas_lost, crc_timeout;
  logic [5:0] crc_retry;

  e1_frame_sync u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .crc4_en(crc4_en),
    .frame_stb(frame_stb), .crc_mf_stb(crc_mf_stb), .cas_mf_stb(cas_mf_stb),
    .fas_search(fas_search), .crc_search(crc_search), .cas_search(cas_search),
    .fas_lost(fas_lost), .crc_timeout(crc_timeout), .crc_retry(crc_retry)
  );

  always #(CLK_T/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, to_cnt = 0, pend = -1;
  logic gappy = 1'b0;
  logic s_fstb, s_crcstb, s_lost, s_fsearch, s_crcsearch, s_casstb, s_cassearch;
  logic [5:0] s_retry;

  // {gap, leading filler bits[6:0], frame0 word ok, frame1 bit2 ok, frame2 word ok, lock expected}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 7'd0,  4'b1111},
    {1'b0, 7'd37, 4'b1111},
    {1'b0, 7'd5,  4'b1010},
    {1'b0, 7'd0,  4'b1100},
    {1'b1, 7'd3,  4'b1111},
    {1'b0, 7'd0,  4'b0110}
  };

  always @(negedge clk) if (rst_n && crc_timeout) to_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample_pend();
    if (pend == 7) begin
      s_fstb = frame_stb; s_crcstb = crc_mf_stb; s_lost = fas_lost;
      s_fsearch = fas_search; s_crcsearch = crc_search; s_retry = crc_retry;
    end
    if (pend == 135) begin s_casstb = cas_mf_stb; s_cassearch = cas_search; end
    pend = -1;
  endtask

  task automatic send_bit(input logic b, input int j);
    @(negedge clk); sample_pend();
    bit_en = 1'b1; rx_bit = b; pend = j;
    if (gappy) begin
      @(negedge clk); sample_pend();
      bit_en = 1'b0; rx_bit = ~b;
    end
  endtask

  function automatic logic mfbit(input int k);
    return (k == 1 || k == 3 || k == 7) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_frame(input int idx, input logic fas_good, input logic nfas_good,
                            input logic mf_on, input logic [7:0] ts16);
    logic [7:0] ts0;
    logic si;
    logic b;
    si = (idx % 2 == 1 && mf_on) ? mfbit(idx % 16) : 1'b1;
    if (idx % 2 == 0) ts0 = {si, fas_good ? 7'b0011011 : 7'b0011010};
    else              ts0 = {si, nfas_good, 6'b111111};
    for (int j = 0; j < 256; j++) begin
      b = (j < 8) ? ts0[7-j] : (j >= 128 && j < 136) ? ts16[135-j] : 1'b1;
      send_bit(b, j);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; pend = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; to_cnt = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 fas_search", fas_search, 1);
    check("R1 crc_search", crc_search, 0);
    check("R1 cas_search", cas_search, 0);
    check("R1 crc_retry", crc_retry, 0);
    check("R1 strobes", {frame_stb, crc_mf_stb, cas_mf_stb, fas_lost, crc_timeout}, 0);

    // R3 R4 R2 vector table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      crc4_en = 1'b0;
      gappy = VEC[v][11];
      for (int k = 0; k < int'(VEC[v][10:4]); k++) send_bit(1'b1, 300);
      send_frame(0, VEC[v][3], 1'b1, 1'b0, 8'hFF);
      send_frame(1, 1'b1, VEC[v][2], 1'b0, 8'hFF);
      send_frame(2, VEC[v][1], 1'b1, 1'b0, 8'hFF);
      check(VEC[v][0] ? "R3 lock at frame N+2" : (gappy ? "R2" : "R4 no lock"),
            s_fsearch, VEC[v][0] ? 0 : 1);
      for (int f = 3; f < 8; f++) send_frame(f, 1'b1, 1'b1, 1'b0, 8'hFF);
      check(gappy ? "R2 lock with idle cycles" : "R4 relock after restart", s_fsearch, 0);
      gappy = 1'b0;
    end

    // R5 R6 strobe and loss
    do_reset();
    crc4_en = 1'b0;
    for (int f = 0; f < 17; f++) begin
      logic good;
      good = !(f == 6 || f == 8 || f == 12 || f == 14 || f == 16);
      send_frame(f, good, 1'b1, 1'b0, 8'hFF);
      if (f == 4)  check("R5 strobe after alignment frame", s_fstb, 1);
      if (f == 5)  check("R5 no strobe after non-alignment frame", s_fstb, 0);
      if (f == 10) check("R6 lock kept after two errors", s_fsearch, 0);
      if (f == 14) check("R6 no loss after two errors", s_lost, 0);
      if (f == 16) begin
        check("R6 loss pulse", s_lost, 1);
        check("R6 search restarts", s_fsearch, 1);
      end
    end

    // R7 R8 CRC-4 lock
    do_reset();
    crc4_en = 1'b1;
    for (int f = 0; f < 33; f++) begin
      send_frame(f, 1'b1, 1'b1, 1'b1, 8'hFF);
      if (f == 2)  check("R7 crc search starts", s_crcsearch, 1);
      if (f == 25) check("R7 crc search before second word", s_crcsearch, 1);
      if (f == 27) check("R7 crc lock on second word", s_crcsearch, 0);
      if (f == 30) check("R8 no mf strobe mid multiframe", s_crcstb, 0);
      if (f == 32) check("R8 mf strobe at frame 0", s_crcstb, 1);
    end

    // R9 R10 timeout and retry
    do_reset();
    crc4_en = 1'b1;
    for (int f = 0; f < 176; f++) begin
      send_frame(f, 1'b1, 1'b1, f >= 140, 8'hFF);
      if (f == 65) check("R9 retry before window end", s_retry, 0);
      if (f == 66) begin
        check("R9 retry after window", s_retry, 1);
        check("R9 frame hunt restarts", s_fsearch, 1);
      end
      if (f == 139) check("R9 two timeouts", to_cnt, 2);
      if (f == 139) check("R9 retry count two", s_retry, 2);
    end
    check("R10 retry cleared on lock", s_retry, 0);
    check("R10 crc locked", s_crcsearch, 0);

    // R11 R12 CAS, R7 with CRC-4 off
    do_reset();
    crc4_en = 1'b0;
    for (int f = 0; f < 81; f++) begin
      logic [7:0] t16;
      t16 = (f == 2) ? 8'h00 : (f == 3 || f == 19) ? 8'h0B : 8'hFF;
      send_frame(f, 1'b1, 1'b1, 1'b0, t16);
      if (f == 3)  check("R11 zero previous slot blocks lock", s_cassearch, 1);
      if (f == 19) check("R11 cas lock", s_cassearch, 0);
      if (f == 34) check("R12 no cas strobe early", s_casstb, 0);
      if (f == 35) check("R12 cas strobe 16 frames on", s_casstb, 1);
    end
    check("R7 no timeout when disabled", to_cnt, 0);
    check("R7 crc search idle when disabled", s_crcsearch, 0);

    @(negedge clk); bit_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule